// File: doc/BRIEF.md
# Qualified Bus Trace Capture

This block sits beside a processor bus and records selected bus cycles into an on-chip circular buffer without ever holding the bus. Each cycle on the bus is checked against a filter: its address must lie inside an inclusive window, and its cycle kind (read, write or instruction fetch) must be enabled in a mask. Each cycle that passes while capture is running becomes one record. The record holds the address, the data, the processor status bits, the external probe inputs and the value of a free-running time counter. Because the time value is absolute, the gaps left by filtering can still be measured.

Capture starts on a start pulse and ends on a stop pulse, so no breakpoint is needed and the target keeps running. Two buffer policies are selectable. In the first, capture halts once the buffer is full and the first records are kept. In the second, the oldest records are overwritten and the most recent ones are kept. When capture is idle, a host drains the buffer one record per request, oldest first, and watches a count of the records that remain.

Top module: `bus_trace_capture`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `capturing`, `full` and `rd_valid` are 0 and `entry_count` is 0.
- R2: A bus cycle is stored only if `cfg_addr_lo <= bus_addr <= cfg_addr_hi`, with both bounds inclusive.
- R3: `bus_kind` is encoded 0 for read, 1 for write, 2 for fetch and 3 for no transfer. A cycle is stored only if `bus_valid` is 1, the kind is not 3, and bit `bus_kind` of `cfg_kind_mask` is 1.
- R4: Every stored record returns the address, data, status and external inputs of its bus cycle unchanged. Its time field is the value of a counter that is 0 while `rst` is high and rises by one on each clock edge after that, sampled in the cycle the bus cycle was presented. The counter wraps silently.
- R5: A `trig_start` while idle, with no `trig_stop` in the same cycle, empties the buffer and begins capture. A qualifying bus cycle in that same cycle becomes the first record. A `trig_start` while already capturing is ignored and the buffer is kept.
- R6: A `trig_stop` ends capture from the next cycle on. A bus cycle in the same cycle as `trig_stop` is not stored, and `trig_stop` overrides a `trig_start` in the same cycle.
- R7: With `cfg_wrap` = 0, once DEPTH records are held, `full` is 1. Further qualifying cycles are dropped and the first DEPTH records are kept.
- R8: With `cfg_wrap` = 1, a qualifying cycle that arrives when the buffer is full overwrites the oldest record. `entry_count` stays at DEPTH and readout returns the most recent DEPTH records.
- R9: When idle, a `rd_req` with `entry_count` > 0 presents the oldest record with `rd_valid` = 1 one cycle later, and `entry_count` drops by one. A `rd_req` made while capturing, or when the buffer is empty, gives `rd_valid` = 0 and leaves the count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | A bus cycle is present this clock |
| bus_kind | input | 2 | Cycle kind: 0 read, 1 write, 2 fetch, 3 none |
| bus_addr | input | ADDR_W | Bus address |
| bus_data | input | DATA_W | Bus data |
| bus_stat | input | STAT_W | Processor status bits |
| ext_in | input | EXT_W | External probe inputs |
| cfg_addr_lo | input | ADDR_W | Lower bound of the address window (inclusive) |
| cfg_addr_hi | input | ADDR_W | Upper bound of the address window (inclusive) |
| cfg_kind_mask | input | 3 | Enable per kind: bit0 read, bit1 write, bit2 fetch |
| cfg_wrap | input | 1 | 1 = overwrite oldest, 0 = halt when full |
| trig_start | input | 1 | Start pulse |
| trig_stop | input | 1 | Stop pulse |
| rd_req | input | 1 | Request the oldest record |
| capturing | output | 1 | Capture is running |
| entry_count | output | $clog2(DEPTH)+1 | Records held |
| full | output | 1 | Buffer holds DEPTH records |
| rd_valid | output | 1 | Read record is valid this cycle |
| rd_addr | output | ADDR_W | Record address |
| rd_data | output | DATA_W | Record data |
| rd_stat | output | STAT_W | Record status |
| rd_stamp | output | TS_W | Record time value |
| rd_ext | output | EXT_W | Record external inputs |

## Verification
Three things can land in the same clock: a trigger edge and a qualifying bus cycle, or a start and a stop together. The bench presents a qualifying cycle in the very clock of a start pulse and expects it as the first record. It presents another in the clock of a stop pulse and expects it to be absent. It also raises start and stop together while idle and expects `capturing` to stay low. These cases are judged by the record count and by the scoreboard, which compares every drained record, time field included, against a model queue.

// File: rtl/trc_pkg.sv
package trc_pkg;

  typedef enum logic [1:0] {
    KIND_RD    = 2'd0,
    KIND_WR    = 2'd1,
    KIND_FETCH = 2'd2,
    KIND_NONE  = 2'd3
  } bus_kind_e;

  // True when the cycle kind is enabled by the three-bit mask.
  function automatic logic kind_enabled(bus_kind_e kind, logic [2:0] mask);
    case (kind)
      KIND_RD:    kind_enabled = mask[0];
      KIND_WR:    kind_enabled = mask[1];
      KIND_FETCH: kind_enabled = mask[2];
      default:    kind_enabled = 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/trc_filter.sv
module trc_filter #(
  parameter int ADDR_W = 16
) (
  input  logic              valid,
  input  trc_pkg::bus_kind_e kind,
  input  logic [ADDR_W-1:0] addr,
  input  logic [ADDR_W-1:0] lo,
  input  logic [ADDR_W-1:0] hi,
  input  logic [2:0]        mask,
  output logic              hit
);

  logic in_window;

  always_comb begin
    in_window = (addr >= lo) && (addr <= hi);
    hit       = valid && in_window && trc_pkg::kind_enabled(kind, mask);
  end

endmodule

// File: rtl/trc_stamp.sv
module trc_stamp #(
  parameter int TS_W = 32
) (
  input  logic            clk,
  input  logic            rst,
  output logic [TS_W-1:0] stamp
);

  always_ff @(posedge clk) begin
    if (rst) stamp <= '0;
    else     stamp <= stamp + TS_W'(1);
  end

  // R4
  stamp_step_chk: assert property (@(posedge clk) disable iff (rst)
    !rst |=> stamp == $past(stamp) + TS_W'(1));

endmodule

// File: rtl/trc_store.sv
module trc_store #(
  parameter int ENTRY_W = 72,
  parameter int DEPTH   = 16,
  localparam int AW     = $clog2(DEPTH),
  localparam int CW     = AW + 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               clear,
  input  logic               wr_en,
  input  logic [ENTRY_W-1:0] wr_entry,
  input  logic               wrap,
  input  logic               rd_req,
  output logic [ENTRY_W-1:0] rd_entry,
  output logic               rd_valid,
  output logic [CW-1:0]      count,
  output logic               full
);

  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  logic [ENTRY_W-1:0] mem [DEPTH];
  logic [AW-1:0]      wr_ptr;
  logic [AW-1:0]      eff_ptr;
  logic [CW-1:0]      eff_cnt;
  logic [AW-1:0]      oldest;
  logic               accept;
  logic               grows;
  logic               rd_go;
  logic [CW-1:0]      count_nx;

  always_comb begin
    eff_ptr  = clear ? '0 : wr_ptr;
    eff_cnt  = clear ? '0 : count;
    accept   = wr_en && ((eff_cnt != FULL_CNT) || wrap);
    grows    = accept && (eff_cnt != FULL_CNT);
    rd_go    = rd_req && !clear && !wr_en && (count != '0);
    oldest   = wr_ptr - count[AW-1:0];
    count_nx = eff_cnt;
    if (grows)      count_nx = eff_cnt + CW'(1);
    else if (rd_go) count_nx = eff_cnt - CW'(1);
  end

  // Storage array: no reset, registered read, suited to block RAM.
  always_ff @(posedge clk) begin
    if (accept) mem[eff_ptr] <= wr_entry;
    if (rd_go)  rd_entry     <= mem[oldest];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr   <= '0;
      count    <= '0;
      full     <= 1'b0;
      rd_valid <= 1'b0;
    end else begin
      wr_ptr   <= accept ? eff_ptr + AW'(1) : eff_ptr;
      count    <= count_nx;
      full     <= (count_nx == FULL_CNT);
      rd_valid <= rd_go;
    end
  end

  // R8
  count_bound_chk: assert property (@(posedge clk) disable iff (rst)
    count <= FULL_CNT);

  // R7
  hold_when_full_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wrap && !clear && full) |=> $stable(count));

  // R9
  read_pop_chk: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> ($past(count) != '0 && count == $past(count) - CW'(1)));

endmodule

// File: rtl/bus_trace_capture.sv
module bus_trace_capture #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter int STAT_W = 4,
  parameter int TS_W   = 32,
  parameter int EXT_W  = 4,
  parameter int DEPTH  = 16,
  localparam int CW    = $clog2(DEPTH) + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_valid,
  input  logic [1:0]        bus_kind,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_data,
  input  logic [STAT_W-1:0] bus_stat,
  input  logic [EXT_W-1:0]  ext_in,
  input  logic [ADDR_W-1:0] cfg_addr_lo,
  input  logic [ADDR_W-1:0] cfg_addr_hi,
  input  logic [2:0]        cfg_kind_mask,
  input  logic              cfg_wrap,
  input  logic              trig_start,
  input  logic              trig_stop,
  input  logic              rd_req,
  output logic              capturing,
  output logic [CW-1:0]     entry_count,
  output logic              full,
  output logic              rd_valid,
  output logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic [STAT_W-1:0] rd_stat,
  output logic [TS_W-1:0]   rd_stamp,
  output logic [EXT_W-1:0]  rd_ext
);

  localparam int ENTRY_W = ADDR_W + DATA_W + STAT_W + TS_W + EXT_W;

  logic               hit;
  logic [TS_W-1:0]    stamp;
  logic               start_go;
  logic               cap_now;
  logic               store_en;
  logic               read_ok;
  logic [ENTRY_W-1:0] new_entry;
  logic [ENTRY_W-1:0] out_entry;

  trc_filter #(.ADDR_W(ADDR_W)) u_filter (
    .valid (bus_valid),
    .kind  (trc_pkg::bus_kind_e'(bus_kind)),
    .addr  (bus_addr),
    .lo    (cfg_addr_lo),
    .hi    (cfg_addr_hi),
    .mask  (cfg_kind_mask),
    .hit   (hit)
  );

  trc_stamp #(.TS_W(TS_W)) u_stamp (
    .clk   (clk),
    .rst   (rst),
    .stamp (stamp)
  );

  // Stop dominates; start only acts while idle.
  always_comb begin
    start_go  = trig_start && !trig_stop && !capturing;
    cap_now   = (capturing || start_go) && !trig_stop;
    store_en  = cap_now && hit;
    read_ok   = rd_req && !capturing && !trig_start;
    new_entry = {bus_addr, bus_data, bus_stat, stamp, ext_in};
  end

  always_ff @(posedge clk) begin
    if (rst)            capturing <= 1'b0;
    else if (trig_stop) capturing <= 1'b0;
    else if (start_go)  capturing <= 1'b1;
  end

  trc_store #(.ENTRY_W(ENTRY_W), .DEPTH(DEPTH)) u_store (
    .clk      (clk),
    .rst      (rst),
    .clear    (start_go),
    .wr_en    (store_en),
    .wr_entry (new_entry),
    .wrap     (cfg_wrap),
    .rd_req   (read_ok),
    .rd_entry (out_entry),
    .rd_valid (rd_valid),
    .count    (entry_count),
    .full     (full)
  );

  assign {rd_addr, rd_data, rd_stat, rd_stamp, rd_ext} = out_entry;

  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (!capturing && entry_count == '0 && !rd_valid && !full));

  // R6
  stop_ends_chk: assert property (@(posedge clk) disable iff (rst)
    trig_stop |=> !capturing);

  // R5
  start_clears_chk: assert property (@(posedge clk) disable iff (rst)
    (trig_start && !trig_stop && !capturing) |=> (capturing && entry_count <= CW'(1)));

  // R9
  idle_read_only_chk: assert property (@(posedge clk) disable iff (rst)
    capturing |=> !rd_valid);

endmodule

// File: tb/tb_bus_trace_capture.sv
module tb_bus_trace_capture;

  localparam int ADDR_W = 16;
  localparam int DATA_W = 16;
  localparam int STAT_W = 4;
  localparam int TS_W   = 32;
  localparam int EXT_W  = 4;
  localparam int DEPTH  = 16;
  localparam int CW     = $clog2(DEPTH) + 1;

  typedef struct {
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
    logic [STAT_W-1:0] stat;
    logic [TS_W-1:0]   stamp;
    logic [EXT_W-1:0]  ext;
  } rec_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic              bus_valid = 1'b0;
  logic [1:0]        bus_kind = 2'd3;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [DATA_W-1:0] bus_data = '0;
  logic [STAT_W-1:0] bus_stat = '0;
  logic [EXT_W-1:0]  ext_in = '0;
  logic [ADDR_W-1:0] cfg_addr_lo = '0;
  logic [ADDR_W-1:0] cfg_addr_hi = '1;
  logic [2:0]        cfg_kind_mask = 3'b111;
  logic              cfg_wrap = 1'b0;
  logic              trig_start = 1'b0;
  logic              trig_stop = 1'b0;
  logic              rd_req = 1'b0;
  logic              capturing;
  logic [CW-1:0]     entry_count;
  logic              full;
  logic              rd_valid;
  logic [ADDR_W-1:0] rd_addr;
  logic [DATA_W-1:0] rd_data;
  logic [STAT_W-1:0] rd_stat;
  logic [TS_W-1:0]   rd_stamp;
  logic [EXT_W-1:0]  rd_ext;

  int checks = 0;
  int fails  = 0;
  rec_t exp_q[$];
  bit   m_cap = 0;
  logic [TS_W-1:0] ref_time;

  always #4 clk = ~clk;

  // Reference time: 0 under reset, +1 per edge afterwards (R4).
  always_ff @(posedge clk) begin
    if (rst) ref_time <= '0;
    else     ref_time <= ref_time + TS_W'(1);
  end

  bus_trace_capture #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .STAT_W(STAT_W),
    .TS_W(TS_W), .EXT_W(EXT_W), .DEPTH(DEPTH)
  ) dut (
    .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_kind(bus_kind),
    .bus_addr(bus_addr), .bus_data(bus_data), .bus_stat(bus_stat),
    .ext_in(ext_in), .cfg_addr_lo(cfg_addr_lo), .cfg_addr_hi(cfg_addr_hi),
    .cfg_kind_mask(cfg_kind_mask), .cfg_wrap(cfg_wrap),
    .trig_start(trig_start), .trig_stop(trig_stop), .rd_req(rd_req),
    .capturing(capturing), .entry_count(entry_count), .full(full),
    .rd_valid(rd_valid), .rd_addr(rd_addr), .rd_data(rd_data),
    .rd_stat(rd_stat), .rd_stamp(rd_stamp), .rd_ext(rd_ext)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Driver: presents one bus clock and updates the model queue.
  task automatic drive(input bit v, input logic [1:0] k, input logic [ADDR_W-1:0] a,
                       input logic [DATA_W-1:0] d, input bit st, input bit sp);
    bit qual;
    rec_t r;
    bus_valid  = v;
    bus_kind   = k;
    bus_addr   = a;
    bus_data   = d;
    bus_stat   = STAT_W'(a[3:0] ^ 4'h5);
    ext_in     = EXT_W'(d[3:0]);
    trig_start = st;
    trig_stop  = sp;
    if (sp) m_cap = 0;
    else if (st && !m_cap) begin
      exp_q.delete();
      m_cap = 1;
    end
    qual = v && (k != 2'd3) && cfg_kind_mask[k] &&
           (a >= cfg_addr_lo) && (a <= cfg_addr_hi);
    if (m_cap && qual) begin
      r.addr = a; r.data = d; r.stat = bus_stat; r.stamp = ref_time; r.ext = ext_in;
      if (exp_q.size() < DEPTH) exp_q.push_back(r);
      else if (cfg_wrap) begin
        void'(exp_q.pop_front());
        exp_q.push_back(r);
      end
    end
    @(negedge clk);
    bus_valid  = 0;
    trig_start = 0;
    trig_stop  = 0;
  endtask

  // Monitor: pops and compares each record the design presents (R4, R9).
  always @(negedge clk) begin
    if (!rst && rd_valid) begin
      if (exp_q.size() == 0) begin
        check(0, "R9", "unexpected record", rd_addr, 0);
      end else begin
        rec_t e;
        e = exp_q.pop_front();
        check(rd_addr == e.addr,   "R4", "rec addr",  rd_addr,  e.addr);
        check(rd_data == e.data,   "R4", "rec data",  rd_data,  e.data);
        check(rd_stat == e.stat,   "R4", "rec stat",  rd_stat,  e.stat);
        check(rd_stamp == e.stamp, "R4", "rec stamp", rd_stamp, e.stamp);
        check(rd_ext == e.ext,     "R4", "rec ext",   rd_ext,   e.ext);
      end
    end
  end

  task automatic drain(input string req);
    int n;
    n = exp_q.size();
    check(entry_count == CW'(n), req, "count before drain", entry_count, n);
    for (int i = 0; i < n; i++) begin
      rd_req = 1;
      @(negedge clk);
    end
    rd_req = 0;
    @(negedge clk);
    @(negedge clk);
    check(exp_q.size() == 0, req, "records left unread", exp_q.size(), 0);
    check(entry_count == '0, "R9", "count after drain", entry_count, 0);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #(8 * 20000);
    check(0, "watchdog", "run timed out", 0, 1);
    finish_run();
  end

  initial begin
    @(negedge clk);
    @(negedge clk);
    check(!capturing && entry_count == '0 && !full && !rd_valid, "R1",
          "state in reset", {capturing, full, rd_valid}, 0);
    rst = 0;
    @(negedge clk);
    check(!capturing && entry_count == '0 && !full && !rd_valid, "R1",
          "state after reset", {capturing, full, rd_valid}, 0);

    // Window and kind filtering.
    cfg_addr_lo = 16'h0100; cfg_addr_hi = 16'h01FF; cfg_kind_mask = 3'b111; cfg_wrap = 0;
    drive(1, 2'd0, 16'h0150, 16'hA001, 1, 0);  // R5 start with qualifying cycle
    check(capturing == 1, "R5", "capturing after start", capturing, 1);
    check(entry_count == CW'(1), "R5", "record stored in start cycle", entry_count, 1);
    drive(1, 2'd1, 16'h00FF, 16'hA002, 0, 0);  // R2 below window
    drive(1, 2'd1, 16'h0100, 16'hA003, 0, 0);  // R2 low bound
    drive(1, 2'd2, 16'h01FF, 16'hA004, 0, 0);  // R2 high bound
    drive(1, 2'd0, 16'h0200, 16'hA005, 0, 0);  // R2 above window
    drive(1, 2'd3, 16'h0150, 16'hA006, 0, 0);  // R3 kind none
    drive(0, 2'd1, 16'h0150, 16'hA007, 0, 0);  // R3 not valid
    check(entry_count == CW'(3), "R2", "count after window cycles", entry_count, 3);
    cfg_kind_mask = 3'b010;
    drive(1, 2'd0, 16'h0120, 16'hB001, 0, 0);  // R3 read masked
    drive(1, 2'd1, 16'h0130, 16'hB002, 0, 0);  // R3 write passes
    drive(1, 2'd2, 16'h0140, 16'hB003, 0, 0);  // R3 fetch masked
    check(entry_count == CW'(4), "R3", "count after mask cycles", entry_count, 4);
    drive(1, 2'd1, 16'h0131, 16'hB004, 1, 0);  // R5 start while capturing ignored
    check(entry_count == CW'(5), "R5", "start while capturing keeps buffer", entry_count, 5);
    rd_req = 1;                                 // R9 read while capturing
    @(negedge clk);
    rd_req = 0;
    @(negedge clk);
    check(!rd_valid && entry_count == CW'(5), "R9", "read during capture ignored",
          entry_count, 5);
    drive(1, 2'd1, 16'h0132, 16'hB005, 0, 1);  // R6 stop with qualifying cycle
    check(!capturing, "R6", "capturing after stop", capturing, 0);
    check(entry_count == CW'(5), "R6", "cycle in stop clock dropped", entry_count, 5);
    drive(1, 2'd1, 16'h0133, 16'hB006, 0, 0);  // R6 after stop
    check(entry_count == CW'(5), "R6", "cycle after stop dropped", entry_count, 5);
    drain("R4");
    rd_req = 1;                                 // R9 read on empty buffer
    @(negedge clk);
    rd_req = 0;
    @(negedge clk);
    check(!rd_valid && entry_count == '0, "R9", "read on empty", rd_valid, 0);

    // Stop and start together while idle (R6).
    drive(1, 2'd1, 16'h0134, 16'hB007, 1, 1);
    check(!capturing && entry_count == '0, "R6", "stop overrides start", capturing, 0);

    // Halt when full (R7).
    cfg_kind_mask = 3'b111; cfg_addr_lo = 16'h0000; cfg_addr_hi = 16'hFFFF; cfg_wrap = 0;
    for (int i = 0; i < DEPTH + 4; i++)
      drive(1, 2'(i % 3), 16'(16'h2000 + i), 16'(16'hC000 + i * 7), i == 0, 0);
    check(full == 1, "R7", "full flag", full, 1);
    check(entry_count == CW'(DEPTH), "R7", "count at full", entry_count, DEPTH);
    drive(0, 2'd3, 16'h0, 16'h0, 0, 1);
    drain("R7");
    check(full == 0, "R7", "full clears after drain", full, 0);

    // Overwrite oldest (R8).
    cfg_wrap = 1;
    for (int i = 0; i < DEPTH + 5; i++)
      drive(1, 2'(i % 3), 16'(16'h3000 + i), 16'(16'hD000 + i * 3), i == 0, 0);
    check(entry_count == CW'(DEPTH) && full, "R8", "count stays at depth",
          entry_count, DEPTH);
    drive(0, 2'd3, 16'h0, 16'h0, 0, 1);
    drain("R8");

    finish_run();
  end

endmodule